// File: doc/BRIEF.md
# Serial Code Combination Lock

This block is a small sequential lock controller. It takes a single serial code bit on every rising clock edge and compares the arriving bits, one at a time, against a secret code fixed at build time through a parameter. When every bit of the code has arrived in order and matched, the lock output drops to 0 (released). It stays released only while the serial input is held at 1. A 0 on the serial input while released returns the block to its idle state, with the lock engaged and a fresh code expected.

A single wrong bit ends the attempt at once. The alarm output rises and stays high whatever arrives afterwards, and the lock stays engaged. Only the synchronous, active-high reset clears the alarm. Reset overrides the serial input on the same edge.

There is no handshake on the serial input: every clock edge consumes one bit. Both outputs are registered and decoded from the state the block enters on that edge. They therefore change on the same edge as the state.

Top module: `seq_code_lock`

## Requirements
- R1: On a clock edge with `rst_i` at 1, the block enters idle: `locked_o` is 1 and `alarm_o` is 0 after that edge.
- R2: Starting from idle, the code bits are expected in order from `SECRET[CODE_LEN-1]` (first) down to `SECRET[0]` (last). After each of the first `CODE_LEN-1` correct bits, `locked_o` stays 1. After the edge that samples the last correct bit, `locked_o` is 0.
- R3: While released, every edge that samples `code_bit_i` at 1 keeps `locked_o` at 0 and `alarm_o` at 0.
- R4: While released, an edge that samples `code_bit_i` at 0 sets `locked_o` to 1 without raising `alarm_o`. The following `CODE_LEN` bits are then checked as a fresh code.
- R5: The first bit that differs from the expected code bit sets `alarm_o` to 1 on the edge that samples it. The block does not wait for the rest of the code.
- R6: Once `alarm_o` is 1, it stays 1 for any values on `code_bit_i`, including the full correct code, and `locked_o` stays 1.
- R7: Only reset clears the alarm. Reset takes priority over `code_bit_i`, so a bit sampled on a reset edge is never counted as part of the code.
- R8: `locked_o` is 0 only while `alarm_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one code bit is sampled per rising edge |
| rst_i | input | 1 | Synchronous active-high reset to idle; clears alarm |
| code_bit_i | input | 1 | Serial code bit; also the hold-open level while released |
| locked_o | output | 1 | 1 = locked, 0 = released |
| alarm_o | output | 1 | 1 = wrong code entered, held until reset |

## Verification
The code checker is driven with every one of the 32 possible five-bit entries from idle. This separates the single accepting entry from all others, and for each rejected entry it confirms that the alarm rises on exactly the first differing bit rather than at the end. A table of patterns covers:
- opening, holding open and dropping back to idle, followed by a second opening, which shows that the relock leaves no stale progress;
- feeding the correct code after an alarm, which tells a sticky alarm from one that a later match would clear.

Directed sequences then apply reset partway through a code, while released, and while the code bits are present on the input. This shows that reset overrides the data and that the bits sampled on reset edges are not counted.

// File: rtl/lock_pkg.sv
package lock_pkg;
  typedef enum logic [1:0] {
    MODE_WAIT  = 2'd0,
    MODE_OPEN  = 2'd1,
    MODE_ALARM = 2'd2
  } lock_mode_e;
endpackage

// File: rtl/code_matcher.sv
module code_matcher #(
  parameter int                  CODE_LEN = 5,
  parameter logic [CODE_LEN-1:0] SECRET   = 5'b10110,
  localparam int                 CW       = $clog2(CODE_LEN)
) (
  input  logic [CW-1:0] pos_i,
  input  logic          bit_i,
  output logic          bit_ok_o,
  output logic          last_o
);
  logic [CW-1:0] idx;
  logic          want;

  // First arriving bit is compared against the top bit of SECRET.
  always_comb begin
    idx      = CW'(CODE_LEN - 1) - pos_i;
    want     = SECRET[idx];
    bit_ok_o = (bit_i == want);
    last_o   = (pos_i == CW'(CODE_LEN - 1));
  end
endmodule

// File: rtl/lock_next_state.sv
module lock_next_state
  import lock_pkg::*;
#(
  parameter int  CODE_LEN = 5,
  localparam int CW       = $clog2(CODE_LEN)
) (
  input  logic          rst_i,
  input  logic          bit_i,
  input  lock_mode_e    mode_i,
  input  logic [CW-1:0] pos_i,
  input  logic          bit_ok_i,
  input  logic          last_i,
  output lock_mode_e    mode_o,
  output logic [CW-1:0] pos_o
);
  always_comb begin
    mode_o = mode_i;
    pos_o  = pos_i;
    if (rst_i) begin
      mode_o = MODE_WAIT;
      pos_o  = '0;
    end else begin
      unique case (mode_i)
        MODE_WAIT: begin
          if (!bit_ok_i) begin
            mode_o = MODE_ALARM;
            pos_o  = '0;
          end else if (last_i) begin
            mode_o = MODE_OPEN;
            pos_o  = '0;
          end else begin
            pos_o = pos_i + 1'b1;
          end
        end
        MODE_OPEN: begin
          if (!bit_i) begin
            mode_o = MODE_WAIT;
            pos_o  = '0;
          end
        end
        MODE_ALARM: begin
          mode_o = MODE_ALARM;
        end
        default: begin
          mode_o = MODE_ALARM;
          pos_o  = '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/lock_out_reg.sv
module lock_out_reg
  import lock_pkg::*;
(
  input  logic       clk,
  input  lock_mode_e mode_n_i,
  output logic       locked_o,
  output logic       alarm_o
);
  // Moore decode of the state being entered, registered alongside it.
  always_ff @(posedge clk) begin
    locked_o <= (mode_n_i != MODE_OPEN);
    alarm_o  <= (mode_n_i == MODE_ALARM);
  end
endmodule

// File: rtl/seq_code_lock.sv
module seq_code_lock
  import lock_pkg::*;
#(
  parameter int                  CODE_LEN = 5,
  parameter logic [CODE_LEN-1:0] SECRET   = 5'b10110
) (
  input  logic clk,
  input  logic rst_i,
  input  logic code_bit_i,
  output logic locked_o,
  output logic alarm_o
);
  localparam int CW = $clog2(CODE_LEN);

  lock_mode_e    mode_q, mode_n;
  logic [CW-1:0] pos_q, pos_n;
  logic          bit_ok, last_bit;

  code_matcher #(.CODE_LEN(CODE_LEN), .SECRET(SECRET)) u_match (
    .pos_i    (pos_q),
    .bit_i    (code_bit_i),
    .bit_ok_o (bit_ok),
    .last_o   (last_bit)
  );

  lock_next_state #(.CODE_LEN(CODE_LEN)) u_next (
    .rst_i    (rst_i),
    .bit_i    (code_bit_i),
    .mode_i   (mode_q),
    .pos_i    (pos_q),
    .bit_ok_i (bit_ok),
    .last_i   (last_bit),
    .mode_o   (mode_n),
    .pos_o    (pos_n)
  );

  always_ff @(posedge clk) begin
    mode_q <= mode_n;
    pos_q  <= pos_n;
  end

  lock_out_reg u_out (
    .clk      (clk),
    .mode_n_i (mode_n),
    .locked_o (locked_o),
    .alarm_o  (alarm_o)
  );
endmodule

// File: rtl/lock_checker.sv
module lock_checker #(
  parameter int                  CODE_LEN = 5,
  parameter logic [CODE_LEN-1:0] SECRET   = 5'b10110
) (
  input logic clk,
  input logic rst_i,
  input logic code_bit_i,
  input logic locked_o,
  input logic alarm_o
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst_i |=> (locked_o && !alarm_o));

  // R2: release only on a last bit equal to SECRET[0], never from alarm
  p_release_last_bit_r2: assert property (@(posedge clk) disable iff (rst_i)
    $fell(locked_o) |-> ($past(code_bit_i) == SECRET[0] && !$past(alarm_o)));

  p_hold_open_r3: assert property (@(posedge clk) disable iff (rst_i)
    (!locked_o && code_bit_i) |=> (!locked_o && !alarm_o));

  p_drop_relock_r4: assert property (@(posedge clk) disable iff (rst_i)
    (!locked_o && !code_bit_i) |=> (locked_o && !alarm_o));

  p_alarm_from_wait_r5: assert property (@(posedge clk) disable iff (rst_i)
    $rose(alarm_o) |-> ($past(locked_o) && !$past(rst_i)));

  p_alarm_sticky_r6: assert property (@(posedge clk) disable iff (rst_i)
    alarm_o |=> alarm_o);

  p_alarm_only_reset_r7: assert property (@(posedge clk)
    $fell(alarm_o) |-> $past(rst_i));

  p_open_no_alarm_r8: assert property (@(posedge clk) disable iff (rst_i)
    !locked_o |-> !alarm_o);
endmodule

bind seq_code_lock lock_checker #(.CODE_LEN(CODE_LEN), .SECRET(SECRET)) u_chk (
  .clk        (clk),
  .rst_i      (rst_i),
  .code_bit_i (code_bit_i),
  .locked_o   (locked_o),
  .alarm_o    (alarm_o)
);

// File: tb/sim_seq_code_lock.sv
module sim_seq_code_lock;
  localparam logic [4:0] KEY = 5'b10110;

  logic clk = 1'b0;
  logic rst_i = 1'b1;
  logic code_bit_i = 1'b0;
  logic locked_o, alarm_o;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  seq_code_lock #(.CODE_LEN(5), .SECRET(KEY)) u0 (
    .clk(clk), .rst_i(rst_i), .code_bit_i(code_bit_i),
    .locked_o(locked_o), .alarm_o(alarm_o)
  );

  // Entry: {rst, bit, expected locked, expected alarm, requirement index}
  localparam int NV = 27;
  localparam logic [7:0] VEC [NV] = '{
    {4'b1010, 4'd1},                                   // R1 reset
    {4'b0110, 4'd2}, {4'b0010, 4'd2}, {4'b0110, 4'd2}, // R2 code bits 1,0,1
    {4'b0110, 4'd2}, {4'b0000, 4'd2},                  // R2 bits 1,0 -> open
    {4'b0100, 4'd3}, {4'b0100, 4'd3},                  // R3 hold
    {4'b0010, 4'd4},                                   // R4 drop relocks
    {4'b0110, 4'd4}, {4'b0010, 4'd4}, {4'b0110, 4'd4}, // R4 fresh code
    {4'b0110, 4'd4}, {4'b0000, 4'd4},
    {4'b0010, 4'd4},                                   // R4 drop again
    {4'b0011, 4'd5},                                   // R5 wrong first bit
    {4'b0111, 4'd6}, {4'b0011, 4'd6},                  // R6 sticky
    {4'b0111, 4'd6}, {4'b0011, 4'd6}, {4'b0111, 4'd6}, // R6 correct code ignored
    {4'b0111, 4'd6}, {4'b0011, 4'd6},
    {4'b1110, 4'd7},                                   // R7 reset clears
    {4'b0110, 4'd5}, {4'b0010, 4'd5}, {4'b0011, 4'd5}  // R5 wrong third bit
  };

  function automatic string req_name(input int unsigned n);
    case (n)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic exp_lock, input logic exp_alarm);
    checks++;
    if (locked_o !== exp_lock || alarm_o !== exp_alarm) begin
      errors++;
      $display("FAIL %s: locked=%b alarm=%b expected locked=%b alarm=%b",
               req, locked_o, alarm_o, exp_lock, exp_alarm);
    end
    // R8: released implies no alarm, checked on every sample
    checks++;
    if (locked_o === 1'b0 && alarm_o !== 1'b0) begin
      errors++;
      $display("FAIL R8: locked=%b alarm=%b expected alarm=0 while released",
               locked_o, alarm_o);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, return at the next falling edge.
  task automatic step(input logic r, input logic b);
    rst_i = r;
    code_bit_i = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    step(1'b1, 1'b0);
    check("R1", 1'b1, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][7], VEC[i][6]);
      check(req_name(VEC[i][3:0]), VEC[i][5], VEC[i][4]);
    end

    // R2/R5: every five-bit entry from idle, expected values from a bench model
    for (int code = 0; code < 32; code++) begin
      bit bad = 1'b0;
      step(1'b1, 1'b0);
      for (int k = 4; k >= 0; k--) begin
        logic b = code[k];
        if (b != KEY[k]) bad = 1'b1;
        step(1'b0, b);
        check(bad ? "R5" : "R2", !( !bad && k == 0), bad);
      end
    end

    // R7: reset partway through a code; the earlier bits must be forgotten
    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    step(1'b1, 1'b1);
    check("R7", 1'b1, 1'b0);
    step(1'b0, 1'b1); step(1'b0, 1'b0); step(1'b0, 1'b1); step(1'b0, 1'b1);
    check("R7", 1'b1, 1'b0);
    step(1'b0, 1'b0);
    check("R7", 1'b0, 1'b0);

    // R7: reset while released wins over a high data bit
    step(1'b1, 1'b1);
    check("R7", 1'b1, 1'b0);

    // R7: code bits on reset edges are not consumed; first bit after reset
    // must be the code's first bit (1), so a 0 here raises the alarm.
    step(1'b1, 1'b1); step(1'b1, 1'b0);
    check("R7", 1'b1, 1'b0);
    step(1'b0, 1'b0);
    check("R7", 1'b1, 1'b1);

    // R6: alarm holds through a long run of highs
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1);
    check("R6", 1'b1, 1'b1);

    // R1: reset out of alarm
    step(1'b1, 1'b0);
    check("R1", 1'b1, 1'b0);

    done = 1'b1;
    finish_run();
  end
endmodule